// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Internal Loopback

This block turns bytes, or 9-bit words, into asynchronous serial frames. A write strobe places a word in a holding register. When the shifter is idle and the transmitter is enabled, the word moves into a frame register together with a start bit, a stop bit and, if selected, a parity bit. The frame is then shifted out least significant bit first. Every bit lasts sixteen pulses of an external bit-rate tick, so the baud generator stays outside the block.

Two status flags report progress. The empty flag means the holding register can take another word. The done flag means the line has gone quiet with nothing left to send. Each flag has its own interrupt enable, and both feed a single interrupt request. A loop mode keeps the output pin in the marking state and sends the frame stream on a separate internal loopback output, which a receiver can use for self-test.

Top module: `sertx_core`

## Requirements
- R1: After reset, tx_line and loop_line are 1, flag_empty and flag_done are 1 and irq is 0.
- R2: A frame is a start bit (0), then the data bits least significant first, then a stop bit (1). With cfg_nine=0 it carries wr_data[7:0] (10 bit times). With cfg_nine=1 it carries wr_data followed by wr_bit8 as the ninth data bit (11 bit times).
- R3: The start bit appears on the line two clock cycles after the cycle in which wr_en is sampled high, provided the shifter is idle and enabled. Each bit then lasts exactly 16 tick pulses.
- R4: With cfg_par_en=1, the last data bit position (bit 7, or bit 8 when cfg_nine=1) carries parity over the data bits below it instead of data. With cfg_par_odd=0 the parity bit is 1 when those bits hold an odd number of ones. With cfg_par_odd=1 it is the inverse. The frame length does not change.
- R5: flag_empty reads 0 in the cycle after a write. It returns to 1 in the cycle after the word moves into the shifter.
- R6: flag_done reads 0 in the cycle after a write. It returns to 1 in the cycle after the 16th tick of a stop bit, but only if no word is waiting. A waiting word is sent next without flag_done rising, after one idle-high cycle.
- R7: irq is 1 exactly when (ie_empty and flag_empty) or (ie_done and flag_done).
- R8: With cfg_loop=1, tx_line stays 1 and the frame appears on loop_line. With cfg_loop=0, loop_line stays 1 and the frame appears on tx_line.
- R9: With cfg_tx_en=0, no frame starts and a written word waits in the holding register. Clearing cfg_tx_en during a frame abandons it, so the line is 1 in the following cycle, and no frame restarts when enable returns unless a new word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Low eight data bits to send |
| wr_bit8 | input | 1 | Ninth data bit, used in 9-bit format |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Replace the top data bit with parity |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_loop | input | 1 | Route the stream to loop_line and hold the pin high |
| cfg_tx_en | input | 1 | Transmitter enable |
| ie_empty | input | 1 | Interrupt enable for flag_empty |
| ie_done | input | 1 | Interrupt enable for flag_done |
| tick | input | 1 | Bit-rate tick, 16 per bit time |
| tx_line | output | 1 | Serial output pin |
| loop_line | output | 1 | Internal loopback stream |
| flag_empty | output | 1 | Holding register empty |
| flag_done | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following: each rise of a flag traces back to a transfer or to a frame end, the shifter stops after its last bit, disabling stops it, a frame opens with a low start bit, and both lines are marking whenever the shifter is idle. Other properties need whole frames and can only be shown by the bench scenarios. These are the bit order and frame length of each format, the even and odd parity values, the exact 16-tick bit timing, back-to-back transfer without a done pulse, abort on disable, and the interrupt combinations.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int OVS     = 16;
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int TCK_W   = $clog2(OVS);

  typedef logic [DATA_W:0]    word_t;
  typedef logic [FRAME_W-1:0] frame_t;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
  } fmt_t;

  // index of the stop bit inside the frame
  function automatic logic [IDX_W-1:0] stop_index(input logic nine);
    return nine ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  endfunction

  // start bit at position 0, data LSB first, parity in top data slot, stop and fill high
  function automatic frame_t build_frame(input word_t w, input fmt_t f);
    int     n;
    logic   p;
    frame_t fr;
    n  = f.nine ? DATA_W + 1 : DATA_W;
    p  = f.par_odd;
    for (int i = 0; i < DATA_W; i++)
      if (i < n - 1) p = p ^ w[i];
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++)
      if (i < n) fr[i+1] = (f.par_en && (i == n - 1)) ? p : w[i];
    return fr;
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_word,
  input  logic  xfer,
  output word_t hold_word,
  output logic  hold_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_word <= wr_word;
      hold_full <= 1'b1;
    end else if (xfer) begin
      hold_full <= 1'b0;
    end
  end

  // R5
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_full) |-> $past(wr_en));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  frame_t           frame_in,
  input  logic [IDX_W-1:0] stop_in,
  input  logic             tick,
  output logic             busy,
  output logic             stream,
  output logic             frame_end
);
  frame_t           shreg;
  logic [TCK_W-1:0] tcnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] stop_q;
  logic             bit_done;
  logic             at_stop;

  assign bit_done  = (tcnt == TCK_W'(OVS - 1));
  assign at_stop   = (idx == stop_q);
  assign frame_end = run & busy & tick & bit_done & at_stop;
  assign stream    = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shreg  <= '1;
      tcnt   <= '0;
      idx    <= '0;
      stop_q <= '0;
    end else if (!run) begin
      busy  <= 1'b0;
      shreg <= '1;
      tcnt  <= '0;
      idx   <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      shreg  <= frame_in;
      tcnt   <= '0;
      idx    <= '0;
      stop_q <= stop_in;
    end else if (busy && tick) begin
      if (bit_done) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        if (at_stop) busy <= 1'b0;
        else         idx  <= idx + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R6
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy);
  // R9
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy);
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= stop_q));
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !stream);
endmodule

// File: rtl/sertx_status.sv
module sertx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic xfer,
  input  logic frame_end,
  input  logic hold_full,
  input  logic ie_empty,
  input  logic ie_done,
  output logic flag_empty,
  output logic flag_done,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_empty <= 1'b1;
      flag_done  <= 1'b1;
    end else begin
      if (wr_en)     flag_empty <= 1'b0;
      else if (xfer) flag_empty <= 1'b1;
      if (wr_en)                       flag_done <= 1'b0;
      else if (frame_end && !hold_full) flag_done <= 1'b1;
    end
  end

  assign irq = (ie_empty & flag_empty) | (ie_done & flag_done);

  // R5
  empty_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_empty) |-> $past(xfer));
  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $past(frame_end));
  // R5
  write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !flag_empty && !flag_done);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit8,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_loop,
  input  logic              cfg_tx_en,
  input  logic              ie_empty,
  input  logic              ie_done,
  input  logic              tick,
  output logic              tx_line,
  output logic              loop_line,
  output logic              flag_empty,
  output logic              flag_done,
  output logic              irq
);
  word_t hold_word;
  logic  hold_full;
  logic  busy;
  logic  stream;
  logic  frame_end;
  logic  xfer;
  fmt_t  fmt;

  assign fmt  = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd};
  assign xfer = cfg_tx_en & hold_full & ~busy;

  sertx_hold hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_word   ({wr_bit8, wr_data}),
    .xfer      (xfer),
    .hold_word (hold_word),
    .hold_full (hold_full)
  );

  sertx_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_tx_en),
    .load      (xfer),
    .frame_in  (build_frame(hold_word, fmt)),
    .stop_in   (stop_index(cfg_nine)),
    .tick      (tick),
    .busy      (busy),
    .stream    (stream),
    .frame_end (frame_end)
  );

  sertx_status status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .xfer       (xfer),
    .frame_end  (frame_end),
    .hold_full  (hold_full),
    .ie_empty   (ie_empty),
    .ie_done    (ie_done),
    .flag_empty (flag_empty),
    .flag_done  (flag_done),
    .irq        (irq)
  );

  assign tx_line   = (cfg_loop | ~cfg_tx_en) ? 1'b1 : stream;
  assign loop_line = cfg_loop ? stream : 1'b1;

  // R8
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_line && loop_line));
  // R8
  loop_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loop && busy) |-> (tx_line && (loop_line == stream)));
endmodule

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_bit8 = 1'b0;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_loop = 1'b0, cfg_tx_en = 1'b0;
  logic       ie_empty = 1'b0, ie_done = 1'b0, tick = 1'b0;
  logic       tx_line, loop_line, flag_empty, flag_done, irq;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  sertx_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_bit8(wr_bit8),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_loop(cfg_loop), .cfg_tx_en(cfg_tx_en), .ie_empty(ie_empty), .ie_done(ie_done),
    .tick(tick), .tx_line(tx_line), .loop_line(loop_line), .flag_empty(flag_empty),
    .flag_done(flag_done), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // expected line value for bit slot k, counted from the start bit
  function automatic logic exp_bit(input int k, input logic [7:0] d, input logic b8,
                                   input logic nine, input logic pe, input logic odd);
    logic [8:0] w;
    int         n, ones;
    w = {b8, d};
    n = nine ? 9 : 8;
    if (k == 0) return 1'b0;
    if (k > n)  return 1'b1;
    if (pe && (k - 1 == n - 1)) begin
      ones = 0;
      for (int i = 0; i < n - 1; i++) ones += w[i];
      return ((ones % 2) == 1) ? ~odd : odd;
    end
    return w[k-1];
  endfunction

  task automatic write_word(input logic [7:0] d, input logic b8);
    wr_data = d;
    wr_bit8 = b8;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // line already shows the start bit; walk every slot at its midpoint
  task automatic walk_frame(input string tag, input logic [7:0] d, input logic b8,
                            input logic nine, input logic pe, input logic odd,
                            input logic lp, input logic expect_done);
    int len;
    len = nine ? 11 : 10;
    for (int k = 0; k < len; k++) begin
      ticks(8);
      chk({tag, " R2 R4 bit"}, lp ? loop_line : tx_line, exp_bit(k, d, b8, nine, pe, odd));
      chk({tag, " R8 idle pin"}, lp ? tx_line : loop_line, 1);
      if (k == len - 1) begin
        ticks(7);
        chk({tag, " R3 stop not over"}, flag_done, 0);
        ticks(1);
        chk({tag, " R6 done after stop"}, flag_done, expect_done);
      end else begin
        ticks(8);
      end
    end
  endtask

  task automatic send_frame(input string tag, input logic [7:0] d, input logic b8,
                            input logic nine, input logic pe, input logic odd, input logic lp);
    cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = odd; cfg_loop = lp; cfg_tx_en = 1'b1;
    write_word(d, b8);
    chk({tag, " R5 empty clears"}, flag_empty, 0);
    chk({tag, " R6 done clears"}, flag_done, 0);
    @(negedge clk);
    chk({tag, " R3 start bit"}, lp ? loop_line : tx_line, 0);
    chk({tag, " R5 empty after transfer"}, flag_empty, 1);
    walk_frame(tag, d, b8, nine, pe, odd, lp, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 tx_line", tx_line, 1);
    chk("R1 loop_line", loop_line, 1);
    chk("R1 flag_empty", flag_empty, 1);
    chk("R1 flag_done", flag_done, 1);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_formats;
    send_frame("8N", 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame("9N", 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send_frame("8E", 8'h07, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame("8O", 8'h07, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    send_frame("9E", 8'hF0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send_frame("9O", 8'h81, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_loop;
    send_frame("LOOP", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    cfg_loop = 1'b0;
  endtask

  task automatic t_irq;
    ie_empty = 1'b1; ie_done = 1'b0; @(negedge clk);
    chk("R7 empty only idle", irq, 1);
    ie_empty = 1'b0; ie_done = 1'b1; @(negedge clk);
    chk("R7 done only idle", irq, 1);
    ie_done = 1'b0; @(negedge clk);
    chk("R7 none", irq, 0);
    ie_empty = 1'b1; ie_done = 1'b1;
    cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_tx_en = 1'b1;
    write_word(8'h11, 1'b0);
    chk("R7 both flags low", irq, 0);
    @(negedge clk);
    ie_empty = 1'b0; #1;
    chk("R7 done enabled while busy", irq, 0);
    ie_empty = 1'b1; ie_done = 1'b0; #1;
    chk("R7 empty enabled while busy", irq, 1);
    ticks(160);
    ie_empty = 1'b0; ie_done = 1'b1; #1;
    chk("R7 done after frame", irq, 1);
    ie_done = 1'b0;
  endtask

  task automatic t_back2back;
    cfg_nine = 1'b0; cfg_par_en = 1'b0; cfg_loop = 1'b0; cfg_tx_en = 1'b1;
    write_word(8'hC3, 1'b0);
    @(negedge clk);
    write_word(8'h96, 1'b0);
    chk("R5 second word waiting", flag_empty, 0);
    walk_frame("B2B-A", 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 idle gap high", tx_line, 1);
    @(negedge clk);
    chk("R6 next start", tx_line, 0);
    chk("R5 empty after second transfer", flag_empty, 1);
    walk_frame("B2B-B", 8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_disable;
    cfg_tx_en = 1'b0; cfg_nine = 1'b0; cfg_par_en = 1'b0;
    write_word(8'h0F, 1'b0);
    repeat (5) @(negedge clk);
    chk("R9 disabled line", tx_line, 1);
    chk("R9 word held", flag_empty, 0);
    cfg_tx_en = 1'b1;
    @(negedge clk);
    chk("R9 start on enable", tx_line, 0);
    ticks(20);
    cfg_tx_en = 1'b0;
    @(negedge clk);
    chk("R9 abort line high", tx_line, 1);
    chk("R9 abort no done", flag_done, 0);
    cfg_tx_en = 1'b1;
    ticks(40);
    chk("R9 no restart", tx_line, 1);
    send_frame("R9 recover", 8'h42, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_formats();
    t_loop();
    t_back2back();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule